// File: doc/BRIEF.md
# Comparator Transition Height Decoder

This block measures pulse heights by watching the single-bit output of an external comparator. The comparator sets the incoming pulse against a triangle reference that an up/down counter produces. Whenever that comparator bit changes, in either direction, the reference level has just crossed the pulse. The counter value in effect at that moment is then the pulse height.

The reference counter value reaches the block as an 8-bit bus, together with a step strobe that marks each counter step. The block keeps the value loaded at the latest strobe. When a crossing is detected, it latches that value as the height and raises a one-cycle valid pulse. The height is also reduced to a coarse bin number. The bin number is held, along with the matching seven-segment pattern, until the next crossing, so a single-digit display can show where recent pulses fall.

The comparator bit is asynchronous to the block clock, so it passes through a two-stage synchronizer before any decision is taken on it. The number of display bins is a parameter, and the default gives eight.

Top module: `phd_height_decoder`

## Requirements
- R1: A change of the comparator input in either direction (low to high, or high to low) is a crossing, and each crossing produces exactly one capture.
- R2: The captured height is the `refCount` value sampled at the most recent clock edge with `stepStrobe` high. A change of `refCount` without a strobe does not affect the height that is captured.
- R3: `heightValid` is high for exactly one clock cycle per crossing. That cycle follows the third rising clock edge after the comparator input changes: two edges in the synchronizer, then one edge into the output registers.
- R4: While the comparator input stays stable, `heightValid` stays low, and `height`, `binIndex` and `segments` keep their last captured values.
- R5: With the default eight bins, the bin number is 1 for a height of 0. For any other height h it is ((h-1) >> 5) + 1. So 0..32 gives 1, 33..64 gives 2, and so on up to 225..255, which gives 8. For example, 166 gives 6 and 254 gives 8.
- R6: `NUM_BINS` is a power of two that sets the number of bins, each 256/`NUM_BINS` counts wide, using the same rule (h = 0 gives bin 1). With 32 bins, for example, 8 gives 1, 9 gives 2 and 166 gives 21. `binIndex` is `$clog2(NUM_BINS+1)` bits wide.
- R7: `segments` is active high, with bit 6 = segment a down to bit 0 = segment g. Digits 1..9 are encoded as 1=0110000, 2=1101101, 3=1111001, 4=0110011, 5=1011011, 6=1011111, 7=1110000, 8=1111111 and 9=1111011. A bin above 9 shows 0000001 (a dash, segment g only).
- R8: While `rstN` is low, `height` is 0, `binIndex` is 1, `heightValid` is 0 and `segments` shows digit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Synchronous reset, active low |
| cmpAsync | input | 1 | Comparator output, asynchronous to clk |
| refCount | input | 8 | Triangle reference counter value |
| stepStrobe | input | 1 | High for one cycle when refCount holds a new step |
| height | output | 8 | Last captured pulse height |
| heightValid | output | 1 | One-cycle pulse when height is updated |
| binIndex | output | $clog2(NUM_BINS+1) | Display bin of the last captured height, 1-based |
| segments | output | 7 | Seven-segment pattern of binIndex, a..g at bits 6..0 |

## Verification
The bench goes after the bin edges 0, 32, 33, 64, 65, 128, 129, 192, 193, 224, 225 and 255. An off-by-one in the bin rule would move a value such as 32 or 33 into the neighbouring bin and show the wrong digit. It alternates rising and falling comparator edges, so a design that detects only one edge direction would miss every second capture. It moves `refCount` without a strobe before a crossing, which exposes a design that samples the live bus instead of the strobed count. It also checks that the valid pulse lands exactly three edges after the input change and lasts one cycle, and it runs a 32-bin instance, where bins above 9 must show a dash instead of a wrapped digit.

// File: rtl/phd_pkg.sv
package phd_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;    // a synchronized comparator edge was seen
    logic loadCount;  // reference count stepped, sample it
  } phdCtlT;

  localparam logic [6:0] SEG_DASH = 7'b0000001;

  // Active-high segments, bit 6 = a ... bit 0 = g
  function automatic logic [6:0] digitSeg(input logic [3:0] d);
    logic [6:0] s;
    case (d)
      4'd0:    s = 7'b1111110;
      4'd1:    s = 7'b0110000;
      4'd2:    s = 7'b1101101;
      4'd3:    s = 7'b1111001;
      4'd4:    s = 7'b0110011;
      4'd5:    s = 7'b1011011;
      4'd6:    s = 7'b1011111;
      4'd7:    s = 7'b1110000;
      4'd8:    s = 7'b1111111;
      4'd9:    s = 7'b1111011;
      default: s = SEG_DASH;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/phd_ctrl.sv
module phd_ctrl
  import phd_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   cmpAsync,
  input  logic   stepStrobe,
  output phdCtlT ctl
);

  logic [1:0] syncQ;   // two-flop synchronizer
  logic       prevQ;   // previous synchronized level

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ <= '0;
      prevQ <= 1'b0;
    end else begin
      syncQ <= {syncQ[0], cmpAsync};
      prevQ <= syncQ[1];
    end
  end

  // Either direction of change is a crossing (R1)
  always_comb begin
    ctl.capture   = syncQ[1] ^ prevQ;
    ctl.loadCount = stepStrobe;
  end

endmodule

// File: rtl/phd_binmap.sv
module phd_binmap
  import phd_pkg::*;
#(
  parameter int HEIGHT_W = 8,
  parameter int NUM_BINS = 8,
  parameter int BIN_W    = $clog2(NUM_BINS + 1)
) (
  input  logic [HEIGHT_W-1:0] heightIn,
  output logic [BIN_W-1:0]    binOut,
  output logic [6:0]          segOut
);

  localparam int SPAN  = (2 ** HEIGHT_W) / NUM_BINS;
  localparam int SHIFT = $clog2(SPAN);

  logic [HEIGHT_W-1:0] belowH;
  logic [HEIGHT_W-1:0] shifted;

  always_comb begin
    belowH  = heightIn - {{(HEIGHT_W-1){1'b0}}, 1'b1};
    shifted = belowH >> SHIFT;
    if (heightIn == '0) binOut = BIN_W'(1);
    else                binOut = BIN_W'(shifted) + BIN_W'(1);
  end

  // Display variant picked by bin count
  generate
    if (NUM_BINS <= 9) begin : g_digitOnly
      assign segOut = digitSeg(4'(binOut));
    end else begin : g_withDash
      assign segOut = (binOut <= BIN_W'(9)) ? digitSeg(4'(binOut)) : SEG_DASH;
    end
  endgenerate

endmodule

// File: rtl/phd_datapath.sv
module phd_datapath
  import phd_pkg::*;
#(
  parameter int HEIGHT_W = 8,
  parameter int NUM_BINS = 8,
  parameter int BIN_W    = $clog2(NUM_BINS + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  phdCtlT              ctl,
  input  logic [HEIGHT_W-1:0] refCount,
  output logic [HEIGHT_W-1:0] height,
  output logic                heightValid,
  output logic [BIN_W-1:0]    binIndex,
  output logic [6:0]          segments
);

  logic [HEIGHT_W-1:0] countQ;
  logic [BIN_W-1:0]    binNext;
  logic [6:0]          segNext;

  always_ff @(posedge clk) begin
    if (!rstN) countQ <= '0;
    else if (ctl.loadCount) countQ <= refCount;
  end

  phd_binmap #(.HEIGHT_W(HEIGHT_W), .NUM_BINS(NUM_BINS), .BIN_W(BIN_W)) u_binmap (
    .heightIn(countQ),
    .binOut  (binNext),
    .segOut  (segNext)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      height      <= '0;
      binIndex    <= BIN_W'(1);
      segments    <= digitSeg(4'd1);
      heightValid <= 1'b0;
    end else begin
      heightValid <= ctl.capture;
      if (ctl.capture) begin
        height   <= countQ;
        binIndex <= binNext;
        segments <= segNext;
      end
    end
  end

endmodule

// File: rtl/phd_height_decoder.sv
module phd_height_decoder
  import phd_pkg::*;
#(
  parameter  int HEIGHT_W = 8,
  parameter  int NUM_BINS = 8,
  localparam int BIN_W    = $clog2(NUM_BINS + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cmpAsync,
  input  logic [HEIGHT_W-1:0] refCount,
  input  logic                stepStrobe,
  output logic [HEIGHT_W-1:0] height,
  output logic                heightValid,
  output logic [BIN_W-1:0]    binIndex,
  output logic [6:0]          segments
);

  phdCtlT ctl;

  phd_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cmpAsync  (cmpAsync),
    .stepStrobe(stepStrobe),
    .ctl       (ctl)
  );

  phd_datapath #(.HEIGHT_W(HEIGHT_W), .NUM_BINS(NUM_BINS), .BIN_W(BIN_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .refCount   (refCount),
    .height     (height),
    .heightValid(heightValid),
    .binIndex   (binIndex),
    .segments   (segments)
  );

endmodule

// File: rtl/phd_checker.sv
module phd_checker #(
  parameter  int HEIGHT_W = 8,
  parameter  int NUM_BINS = 8,
  localparam int BIN_W    = $clog2(NUM_BINS + 1)
) (
  input logic                clk,
  input logic                rstN,
  input logic [HEIGHT_W-1:0] height,
  input logic                heightValid,
  input logic [BIN_W-1:0]    binIndex,
  input logic [6:0]          segments
);

  // R4: height moves only together with the valid pulse
  a_r4_height_hold: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(height) |-> heightValid);

  // R4: display moves only together with the valid pulse
  a_r4_seg_hold: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(segments) |-> heightValid);

  // R6: bin always within 1..NUM_BINS
  a_r6_bin_range: assert property (@(posedge clk) disable iff (!rstN)
    (binIndex >= BIN_W'(1)) && (binIndex <= BIN_W'(NUM_BINS)));

  // R5: zero height lands in the first bin
  a_r5_zero_bin: assert property (@(posedge clk) disable iff (!rstN)
    (height == '0) |-> (binIndex == BIN_W'(1)));

  // R7: bin 1 shows segments b and c
  a_r7_digit_one: assert property (@(posedge clk) disable iff (!rstN)
    (binIndex == BIN_W'(1)) |-> (segments == 7'b0110000));

endmodule

bind phd_height_decoder phd_checker #(.HEIGHT_W(HEIGHT_W), .NUM_BINS(NUM_BINS)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .height     (height),
  .heightValid(heightValid),
  .binIndex   (binIndex),
  .segments   (segments)
);

// File: tb/tb_phd_height_decoder.sv
`timescale 1ns/1ps
module tb_phd_height_decoder;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cmpAsync = 1'b0;
  logic [7:0] refCount = '0;
  logic       stepStrobe = 1'b0;

  logic [7:0] height, height32;
  logic       heightValid, heightValid32;
  logic [3:0] binIndex;
  logic [5:0] binIndex32;
  logic [6:0] segments, segments32;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  phd_height_decoder dut (
    .clk(clk), .rstN(rstN), .cmpAsync(cmpAsync), .refCount(refCount),
    .stepStrobe(stepStrobe), .height(height), .heightValid(heightValid),
    .binIndex(binIndex), .segments(segments)
  );

  phd_height_decoder #(.NUM_BINS(32)) dut32 (
    .clk(clk), .rstN(rstN), .cmpAsync(cmpAsync), .refCount(refCount),
    .stepStrobe(stepStrobe), .height(height32), .heightValid(heightValid32),
    .binIndex(binIndex32), .segments(segments32)
  );

  // Stimulus count and expected default-instance bin and segments (R5, R7)
  typedef struct packed {
    logic [7:0] cnt;
    logic [3:0] expBin;
    logic [6:0] expSeg;
  } vecT;

  localparam int NV = 16;
  localparam vecT VECS [NV] = '{
    '{8'd0,   4'd1, 7'b0110000},
    '{8'd8,   4'd1, 7'b0110000},
    '{8'd9,   4'd1, 7'b0110000},
    '{8'd32,  4'd1, 7'b0110000},
    '{8'd33,  4'd2, 7'b1101101},
    '{8'd64,  4'd2, 7'b1101101},
    '{8'd65,  4'd3, 7'b1111001},
    '{8'd128, 4'd4, 7'b0110011},
    '{8'd129, 4'd5, 7'b1011011},
    '{8'd166, 4'd6, 7'b1011111},
    '{8'd192, 4'd6, 7'b1011111},
    '{8'd193, 4'd7, 7'b1110000},
    '{8'd224, 4'd7, 7'b1110000},
    '{8'd225, 4'd8, 7'b1111111},
    '{8'd254, 4'd8, 7'b1111111},
    '{8'd255, 4'd8, 7'b1111111}
  };

  function automatic logic [6:0] refSeg(input int d);
    case (d)
      1: return 7'b0110000;  2: return 7'b1101101;  3: return 7'b1111001;
      4: return 7'b0110011;  5: return 7'b1011011;  6: return 7'b1011111;
      7: return 7'b1110000;  8: return 7'b1111111;  9: return 7'b1111011;
      default: return 7'b0000001;
    endcase
  endfunction

  function automatic int bin32(input int h);
    return (h == 0) ? 1 : ((h - 1) >> 3) + 1;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic strobeCount(input logic [7:0] c);
    @(negedge clk);
    refCount   = c;
    stepStrobe = 1'b1;
    @(negedge clk);
    stepStrobe = 1'b0;
  endtask

  // Toggle comparator at a negedge, then sample after the third posedge
  task automatic crossAndWait();
    @(negedge clk);
    cmpAsync = ~cmpAsync;
    repeat (2) @(negedge clk);
    check("R3 valid not early", heightValid, 0);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R8: reset state
    check("R8 height", height, 0);
    check("R8 bin", binIndex, 1);
    check("R8 valid", heightValid, 0);
    check("R8 segments", segments, 7'b0110000);
    @(negedge clk);
    rstN = 1'b1;

    // Vector walk, alternating edge direction (R1, R2, R5, R6, R7)
    for (int i = 0; i < NV; i++) begin
      strobeCount(VECS[i].cnt);
      crossAndWait();
      check(cmpAsync ? "R1 rising capture" : "R1 falling capture", heightValid, 1);
      check("R2 height", height, VECS[i].cnt);
      check("R5 bin", binIndex, VECS[i].expBin);
      check("R7 segments", segments, VECS[i].expSeg);
      check("R6 bin32", binIndex32, bin32(VECS[i].cnt));
      check("R7 seg32", segments32, refSeg(bin32(VECS[i].cnt)));
      @(negedge clk);
      check("R3 single-cycle valid", heightValid, 0);
    end

    // R2: live bus change without strobe is ignored
    strobeCount(8'd70);
    @(negedge clk);
    refCount = 8'd200;
    crossAndWait();
    check("R2 unstrobed count ignored", height, 70);
    check("R2 bin for 70", binIndex, 3);

    // R4: stable comparator, nothing moves
    strobeCount(8'd250);
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      check("R4 no valid while stable", heightValid, 0);
      check("R4 height held", height, 70);
      check("R4 segments held", segments, 7'b1111001);
    end

    // R8: reset again in mid-run
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    check("R8 height after reset", height, 0);
    check("R8 bin after reset", binIndex, 1);
    check("R8 segments after reset", segments, 7'b0110000);
    rstN = 1'b1;

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule